// File: doc/BRIEF.md
# Register-Mapped General-Purpose Pin Controller

This block gives software control over up to 64 general-purpose pins through a small byte-addressed register window. The pins are grouped into 32-pin register sets. Each set holds four things: a per-pin direction word, an output latch, a pair of strobe words that raise or lower chosen latch bits in a single write, and a word that returns the synchronized level of each pin. The block drives the pad output value and the output enable of every pin, and samples the pad input of every pin through a two-stage synchronizer.

The register port is a simple single-cycle bus with address, write strobe, write data and read data. Every access completes in the cycle it is presented, so the port has no handshake and no back-pressure. Read data is registered. It appears one clock after the address is presented and reflects the register contents from before any write made in that same cycle. The strobe words let software change individual pins without a read-modify-write sequence. Edge detection and interrupt status live in a neighbouring block, and their word slots in this window read as zero.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every pin is an input: every direction bit reads 1, `pin_oe` is all 0, the output latch and `pin_out` are all 0, and `bus_rdata` is 0.
- R2: Register set n starts at byte address 0x10 + 0x28*n and serves pins 32n to 32n+31, with bit i belonging to pin 32n+i. The word offsets within a set are: 0x00 direction, 0x04 output latch, 0x08 set-strobe, 0x0C clear-strobe and 0x10 input level.
- R3: A direction bit of 1 makes its pin an input and a 0 makes it an output. `pin_oe` for a pin equals the inverse of its direction bit, and it changes right after the clock edge that takes the write. Without a direction write, the direction word holds its value.
- R4: A write to the set-strobe word forces every latch bit written as 1 to 1. Latch bits written as 0 keep their value.
- R5: A write to the clear-strobe word forces every latch bit written as 1 to 0. Latch bits written as 0 keep their value.
- R6: The output latch word can be written and read directly. Reads of the set-strobe and clear-strobe words return the output latch. `pin_out` follows the latch right after the write edge.
- R7: The input-level word returns the pin's sampled level whatever the pin's direction, including pins configured as outputs.
- R8: A change on `pin_in` shows up in `bus_rdata` for an input-level read only after the third rising clock edge following the change. The reads captured at the first and second edges still return the old level.
- R9: `bus_rdata` is registered. It carries the word addressed in the previous cycle as it stood before that cycle's write, so a write shows up in a read issued in the following cycle.
- R10: Addresses that are not mapped read as 0, and writes to them change nothing. These are: addresses below 0x10, the word slots at set offsets 0x14 to 0x24, addresses past the last implemented set, and addresses with nonzero low two bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers and the synchronizer |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe; when high, the access is a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_in | input | 64 | Pad input levels, asynchronous to clk |
| pin_out | output | 64 | Pad output values from the output latch |
| pin_oe | output | 64 | Pad output enables, 1 = drive |

## Verification
Latch and direction writes are due on the pins at the first falling edge after the write edge. Read data is due one edge after the address, and a pin change is due in read data three edges after it occurs. The bench drives every input at a falling edge and samples at the next falling edge, so each sample lands after an exact count of rising edges. For the input path it samples after each of the first three edges, which confirms both the old value during the lag and the new value at the third edge. A separate same-cycle write and read confirms that the read returns the value from before the write.

// File: rtl/gpio_regs_pkg.sv
`timescale 1ns/1ps
package gpio_regs_pkg;

  // Word selected inside one register set; WD_NONE marks an unmapped slot
  typedef enum logic [2:0] {
    WD_DIR  = 3'd0,
    WD_OUT  = 3'd1,
    WD_SET  = 3'd2,
    WD_CLR  = 3'd3,
    WD_IN   = 3'd4,
    WD_NONE = 3'd7
  } word_e;

  localparam int unsigned MAP_BASE   = 32'h10;
  localparam int unsigned MAP_STRIDE = 32'h28;
  localparam int unsigned MAP_SETS   = 5;
  localparam int          SET_W      = 32;

  // Offset inside a set (byte units) to the word it names
  function automatic word_e word_of(input int unsigned rel);
    case (rel)
      32'h00:  return WD_DIR;
      32'h04:  return WD_OUT;
      32'h08:  return WD_SET;
      32'h0C:  return WD_CLR;
      32'h10:  return WD_IN;
      default: return WD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
`timescale 1ns/1ps
module gpio_sync2 #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/gpio_addr_dec.sv
`timescale 1ns/1ps
module gpio_addr_dec
  import gpio_regs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_SETS = 2
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_SETS-1:0] set_sel,
  output word_e               word
);

  logic [31:0] addr_w;
  assign addr_w = 32'(addr);

  always_comb begin
    int unsigned lo;
    word_e       w;
    set_sel = '0;
    word    = WD_NONE;
    for (int b = 0; b < NUM_SETS; b++) begin
      lo = MAP_BASE + MAP_STRIDE * b;
      w  = WD_NONE;
      if (addr_w >= lo && addr_w < lo + MAP_STRIDE && addr[1:0] == 2'b00)
        w = word_of(addr_w - lo);
      if (w != WD_NONE) begin
        set_sel[b] = 1'b1;
        word       = w;
      end
    end
  end

endmodule

// File: rtl/gpio_regset.sv
`timescale 1ns/1ps
module gpio_regset
  import gpio_regs_pkg::*;
#(
  parameter int         W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         wr_en,
  input  word_e        word,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] rd_val
);

  logic [W-1:0] in_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= VALID;
      out_q <= '0;
    end else if (wr_en) begin
      case (word)
        WD_DIR:  dir_q <= wdata & VALID;
        WD_OUT:  out_q <= wdata & VALID;
        WD_SET:  out_q <= out_q | (wdata & VALID);
        WD_CLR:  out_q <= out_q & ~wdata;
        default: ;
      endcase
    end
  end

  gpio_sync2 #(.WIDTH(W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in & VALID),
    .q    (in_q)
  );

  always_comb begin
    rd_val = '0;
    if (sel) begin
      case (word)
        WD_DIR:                 rd_val = dir_q;
        WD_OUT, WD_SET, WD_CLR: rd_val = out_q;
        WD_IN:                  rd_val = in_q;
        default:                rd_val = '0;
      endcase
    end
  end

  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && word == WD_DIR) |=> $stable(dir_q)); // R3

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == WD_SET) |=>
      ((out_q & $past(wdata & VALID)) == $past(wdata & VALID)) &&
      ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata)))); // R4

  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == WD_CLR) |=>
      ((out_q & $past(wdata)) == '0) &&
      ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata)))); // R5

  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == WD_OUT) |=> out_q == $past(wdata & VALID)); // R6

endmodule

// File: rtl/gpio_port_ctrl.sv
`timescale 1ns/1ps
module gpio_port_ctrl
  import gpio_regs_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [SET_W-1:0]    bus_wdata,
  output logic [SET_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  localparam int NUM_SETS = (NUM_PINS + SET_W - 1) / SET_W;

  logic [NUM_SETS-1:0] set_sel;
  word_e               word;
  logic                hit;
  logic [SET_W-1:0]    set_pin_in [NUM_SETS];
  logic [SET_W-1:0]    dir_w      [NUM_SETS];
  logic [SET_W-1:0]    out_w      [NUM_SETS];
  logic [SET_W-1:0]    rd_w       [NUM_SETS];
  logic [SET_W-1:0]    rd_mux;

  gpio_addr_dec #(.ADDR_W(ADDR_W), .NUM_SETS(NUM_SETS)) u_dec (
    .addr   (bus_addr),
    .set_sel(set_sel),
    .word   (word)
  );

  assign hit = |set_sel;

  for (genvar b = 0; b < NUM_SETS; b++) begin : g_set
    localparam int LO  = b * SET_W;
    localparam int CNT = (NUM_PINS - LO < SET_W) ? (NUM_PINS - LO) : SET_W;
    localparam logic [SET_W-1:0] MASK = {SET_W{1'b1}} >> (SET_W - CNT);

    assign set_pin_in[b] = SET_W'(pin_in[LO +: CNT]);

    gpio_regset #(.W(SET_W), .VALID(MASK)) u_set (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (set_sel[b]),
      .wr_en (bus_wr & set_sel[b]),
      .word  (word),
      .wdata (bus_wdata),
      .pin_in(set_pin_in[b]),
      .dir_q (dir_w[b]),
      .out_q (out_w[b]),
      .rd_val(rd_w[b])
    );

    assign pin_out[LO +: CNT] = out_w[b][CNT-1:0];
    assign pin_oe[LO +: CNT]  = ~dir_w[b][CNT-1:0];
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_SETS; b++) rd_mux = rd_mux | rd_w[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;
  end

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> bus_rdata == '0); // R10

  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit) |=> ($stable(pin_out) && $stable(pin_oe))); // R10

endmodule

// File: tb/gpio_port_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_port_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'hFC;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] pin_in = '0;
  logic [63:0] pin_out;
  logic [63:0] pin_oe;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [63:0] exp_out = '0;
  logic [63:0] exp_oe  = '0;

  always #2.5 clk = ~clk;

  gpio_port_ctrl u_gpio_port_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wr    = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_addr  = 8'hFC;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wr   = 1'b0;
    @(negedge clk);
    d = bus_rdata;
    bus_addr = 8'hFC;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 pin_oe", pin_oe, 64'h0);
    chk("R1 pin_out", pin_out, 64'h0);
    chk("R1 rdata", {32'h0, bus_rdata}, 64'h0);
    rd(8'h10, v); chk("R1 dir set0", {32'h0, v}, 64'hFFFF_FFFF);
    rd(8'h38, v); chk("R1 dir set1", {32'h0, v}, 64'hFFFF_FFFF);
    rd(8'h14, v); chk("R1 latch set0", {32'h0, v}, 64'h0);
  endtask

  task automatic t_direction();
    logic [31:0] v;
    wr(8'h10, 32'hFFFF_0000);
    exp_oe[31:0] = 32'h0000_FFFF;
    chk("R3 oe set0", pin_oe, exp_oe);
    wr(8'h38, 32'h7FFF_FFFE);
    exp_oe[63:32] = 32'h8000_0001;
    chk("R3 R2 oe set1", pin_oe, exp_oe);
    rd(8'h38, v); chk("R3 dir readback", {32'h0, v}, 64'h7FFF_FFFE);
  endtask

  task automatic t_latch();
    logic [31:0] v;
    wr(8'h14, 32'hA5A5_0F0F);
    exp_out[31:0] = 32'hA5A5_0F0F;
    chk("R6 pin_out", pin_out, exp_out);
    rd(8'h14, v); chk("R6 latch read", {32'h0, v}, 64'hA5A5_0F0F);
    rd(8'h18, v); chk("R6 set-strobe read", {32'h0, v}, 64'hA5A5_0F0F);
    rd(8'h1C, v); chk("R6 clr-strobe read", {32'h0, v}, 64'hA5A5_0F0F);
  endtask

  task automatic t_set_clear();
    wr(8'h18, 32'h0000_F0F0);
    exp_out[31:0] = 32'hA5A5_FFFF;
    chk("R4 set bits", pin_out, exp_out);
    wr(8'h18, 32'h0);
    chk("R4 zero mask", pin_out, exp_out);
    wr(8'h1C, 32'hA000_000F);
    exp_out[31:0] = 32'h05A5_FFF0;
    chk("R5 clear bits", pin_out, exp_out);
    wr(8'h1C, 32'h0);
    chk("R5 zero mask", pin_out, exp_out);
    wr(8'h40, 32'h8000_0001);
    exp_out[63:32] = 32'h8000_0001;
    chk("R2 R4 set1 strobe", pin_out, exp_out);
    wr(8'h44, 32'h0000_0001);
    exp_out[63:32] = 32'h8000_0000;
    chk("R2 R5 set1 strobe", pin_out, exp_out);
  endtask

  task automatic t_input();
    logic [31:0] v;
    @(negedge clk);
    bus_addr     = 8'h20;
    pin_in[31:0] = 32'h1234_5678;
    @(negedge clk);
    chk("R8 edge1 old", {32'h0, bus_rdata}, 64'h0);
    @(negedge clk);
    chk("R8 edge2 old", {32'h0, bus_rdata}, 64'h0);
    @(negedge clk);
    chk("R8 R7 edge3 new", {32'h0, bus_rdata}, 64'h1234_5678);
    bus_addr = 8'hFC;
    pin_in[63:32] = 32'hCAFE_F00D;
    repeat (3) @(negedge clk);
    rd(8'h48, v); chk("R2 R7 input set1", {32'h0, v}, 64'hCAFE_F00D);
  endtask

  task automatic t_read_timing();
    @(negedge clk);
    bus_addr  = 8'h14;
    bus_wr    = 1'b1;
    bus_wdata = 32'h1111_2222;
    @(negedge clk);
    bus_wr = 1'b0;
    exp_out[31:0] = 32'h1111_2222;
    chk("R9 same-cycle old", {32'h0, bus_rdata}, 64'h05A5_FFF0);
    chk("R6 R9 pin_out", pin_out, exp_out);
    @(negedge clk);
    chk("R9 next-cycle new", {32'h0, bus_rdata}, 64'h1111_2222);
    bus_addr = 8'hFC;
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    logic [7:0] holes [6] = '{8'h00, 8'h24, 8'h34, 8'h4C, 8'h60, 8'h15};
    foreach (holes[i]) wr(holes[i], 32'hFFFF_FFFF);
    chk("R10 pin_out kept", pin_out, exp_out);
    chk("R10 pin_oe kept", pin_oe, exp_oe);
    foreach (holes[i]) begin
      rd(holes[i], v);
      chk("R10 hole reads 0", {32'h0, v}, 64'h0);
    end
    rd(8'h10, v); chk("R10 dir kept", {32'h0, v}, 64'hFFFF_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_latch();
    t_set_clear();
    t_input();
    t_read_timing();
    t_unmapped();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

endmodule